// File: doc/BRIEF.md
# Three-Timer Cluster with Capture and Reload

This block holds one core timer and two auxiliary timers, each 16 bits wide and able to count up or down. Every timer is set up on its own as a prescaled timer, a gated timer (it counts only while its input pin is high) or an event counter that follows edges on its input pin. A direction pin can reverse the software-chosen count direction while the timer runs, for example to follow an incremental position encoder. The core timer drives a toggle latch that flips on every overflow and underflow.

An auxiliary timer can count transitions of the core toggle latch, which chains it onto the core timer to form one long timer. It can also stop counting and serve the core timer in one of two ways. As a capture register it copies the core count when its input pin shows an edge. As a reload register it loads its own value into the core timer, either on an edge of its pin or on a chosen transition of the toggle latch. Software reaches all state through a flat eight-word register port. Each timer has a sticky interrupt flag.

Top module: `gpt_cluster`

## Requirements
- R1: After reset all three counts, all three control words, the toggle latch and the three flags read as zero.
- R2: Control bits [1:0]=0 select timer mode and bit 2 is the run enable. Bits [7:5] hold a prescale select P. A free-running 8-bit prescaler starts at zero after reset, and the timer steps once in each cycle where the low P+1 bits of the prescaler are all ones, so once per 2^(P+1) clocks.
- R3: Mode 1 (gated) steps on the same prescaled ticks as R2, but only while the synchronized input pin of the timer is high.
- R4: Mode 2 (counter) steps once per selected edge of the synchronized input pin. Bit 8 selects rising edges and bit 9 selects falling edges. A pin change made before clock edge k shows in the count after edge k+2.
- R5: Bit 3 set means count down. With bit 4 set, the synchronized direction pin of that timer inverts the direction given by bit 3.
- R6: A timer wraps when it steps up from 0xFFFF to 0 or down from 0 to 0xFFFF. Each core wrap inverts the toggle latch in the same clock edge, and this also happens when a write or a reload replaces the core value.
- R7: An auxiliary timer in counter mode with bit 11 set counts transitions of the toggle latch instead of pin edges, using the edge selects of R4. The count lands on the same clock edge as the core wrap.
- R8: An auxiliary timer in mode 3 with run set and bit 10 clear never counts. On a selected edge of its pin (R4 selects) it takes the core count from just before that clock edge.
- R9: An auxiliary timer in mode 3 with run set and bit 10 set never counts. Its trigger is a selected edge of its pin when bit 12 is clear, or a selected toggle-latch transition (R4 selects) when bit 12 is set. On the trigger it loads its value into the core timer in place of the core's own step. The first auxiliary timer wins when both trigger together.
- R10: Each flag is sticky. The core flag sets on a core wrap. An auxiliary flag sets on its own wrap, capture or winning reload. A write to address 6 clears each flag whose data bit is 1, and a set in the same cycle wins over the clear.
- R11: Addresses 0 to 2 hold the counts (core, first auxiliary, second auxiliary), addresses 3 to 5 hold their 13-bit control words, and address 6 reads flags in bits [2:0] and the toggle latch in bit 3. Address 7 reads zero. A software write to a count takes priority over capture, reload and counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| tin | input | 3 | Gate/clock/capture/reload pins, bit 0 core |
| tdir | input | 3 | Direction pins, bit 0 core |
| core_tl | output | 1 | Core toggle latch |
| irq | output | 3 | Interrupt flags, bit 0 core |

## Verification
Two things can meet in one cycle. One is a capture into the first auxiliary timer. The other is a toggle-latch reload from the second auxiliary timer, which replaces the core wrap on that same edge. The bench sets the second timer to reload on both latch transitions from a value just below the wrap point, so the core wraps again and again. While this runs it keeps toggling the capture pin at a period prime to the wrap period, so some captures fall on reload edges and take the pre-reload core value. A behavioural model in the bench predicts every count, flag and latch state, and the bench compares them on every clock.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int unsigned NTMR     = 3;
  localparam int unsigned PSEL_W   = 3;
  localparam int unsigned PS_DEPTH = 1 << PSEL_W;
  localparam int unsigned CW       = 13;
  localparam logic [2:0]  A_FLAGS  = 3'(2 * NTMR);

  typedef enum logic [1:0] {
    MODE_TIMER   = 2'd0,
    MODE_GATED   = 2'd1,
    MODE_COUNT   = 2'd2,
    MODE_SPECIAL = 2'd3
  } tmode_e;

  typedef struct packed {
    logic              trig_tl;
    logic              src_tl;
    logic              reload;
    logic [1:0]        edge_sel;
    logic [PSEL_W-1:0] psel;
    logic              dpin_en;
    logic              down;
    logic              run;
    tmode_e            mode;
  } tctrl_t;
endpackage

// File: rtl/gpt_pinsync.sv
module gpt_pinsync #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  input  logic [N-1:0] sel_r,
  input  logic [N-1:0] sel_f,
  output logic [N-1:0] lvl,
  output logic [N-1:0] ev
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl = s2_q;
  assign ev  = (sel_r & s2_q & ~s3_q) | (sel_f & ~s2_q & s3_q);
endmodule

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] tick
);
  logic [PW-1:0] cnt_q, cnt_d;

  assign cnt_d = cnt_q + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar k = 0; k < PW; k++) begin : g_tap
    assign tick[k] = &cnt_q[k:0];
  end
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wval,
  input  logic         ld,
  input  logic [W-1:0] lval,
  input  logic         en,
  input  logic         down,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = '1;
  logic [W-1:0] cnt_d;

  assign wrap = en & (down ? (cnt == '0) : (cnt == TOP));

  always_comb begin
    cnt_d = cnt;
    if (wr)      cnt_d = wval;
    else if (ld) cnt_d = lval;
    else if (en) cnt_d = down ? cnt - W'(1) : cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  AST_CNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wr && !ld && !down) |=> cnt == $past(cnt) + W'(1)); // R2
  AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wr && !ld && down) |=> cnt == $past(cnt) - W'(1)); // R5
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr && !ld) |=> $stable(cnt)); // R3
endmodule

// File: rtl/gpt_cluster.sv
module gpt_cluster
  import gpt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [W-1:0]    reg_wdata,
  output logic [W-1:0]    reg_rdata,
  input  logic [NTMR-1:0] tin,
  input  logic [NTMR-1:0] tdir,
  output logic            core_tl,
  output logic [NTMR-1:0] irq
);
  tctrl_t [NTMR-1:0] ctrl_q, ctrl_d;
  logic [W-1:0]      cnt  [NTMR];
  logic [W-1:0]      lval [NTMR];
  logic [W-1:0]      rld_mux;
  logic [NTMR-1:0]   en, wrap, dn, ld, wr, ev, lvl, sr, sf;
  logic [NTMR-1:0]   cap, rld, rld_win, fl_set, fl_clr, fl_q, fl_d;
  logic [NTMR-1:0]   dsy1_q, dsy2_q;
  logic [PS_DEPTH-1:0] tick;
  logic              tl_q, tl_d;

  gpt_pinsync #(.N(NTMR)) u_pins (
    .clk, .rst_n, .pin(tin), .sel_r(sr), .sel_f(sf), .lvl(lvl), .ev(ev)
  );

  gpt_prescaler #(.PW(PS_DEPTH)) u_psc (.clk, .rst_n, .tick(tick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsy1_q <= '0;
      dsy2_q <= '0;
    end else begin
      dsy1_q <= tdir;
      dsy2_q <= dsy1_q;
    end
  end

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    logic en_l, src_l;
    assign sr[i] = ctrl_q[i].edge_sel[0];
    assign sf[i] = ctrl_q[i].edge_sel[1];
    assign wr[i] = reg_we && (reg_addr == 3'(i));
    assign dn[i] = ctrl_q[i].down ^ (ctrl_q[i].dpin_en & dsy2_q[i]);

    if (i == 0) begin : g_core
      assign src_l   = ev[i];
      assign cap[i]  = 1'b0;
      assign rld[i]  = 1'b0;
      assign ld[i]   = |rld_win;
      assign lval[i] = rld_mux;
    end else begin : g_aux
      logic tlev_l, spec_l;
      assign tlev_l  = wrap[0] & ((sr[i] & ~tl_q) | (sf[i] & tl_q));
      assign src_l   = ctrl_q[i].src_tl ? tlev_l : ev[i];
      assign spec_l  = ctrl_q[i].run && (ctrl_q[i].mode == MODE_SPECIAL);
      assign cap[i]  = spec_l & ~ctrl_q[i].reload & ev[i];
      assign rld[i]  = spec_l & ctrl_q[i].reload &
                       (ctrl_q[i].trig_tl ? tlev_l : ev[i]);
      assign ld[i]   = cap[i];
      assign lval[i] = cnt[0];

      AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap[i] && !wr[i]) |=> cnt[i] == $past(cnt[0])); // R8
      AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_win[i] && !wr[0]) |=> cnt[0] == $past(cnt[i])); // R9
    end

    always_comb begin
      unique case (ctrl_q[i].mode)
        MODE_TIMER: en_l = ctrl_q[i].run & tick[ctrl_q[i].psel];
        MODE_GATED: en_l = ctrl_q[i].run & tick[ctrl_q[i].psel] & lvl[i];
        MODE_COUNT: en_l = ctrl_q[i].run & src_l;
        default:    en_l = 1'b0;
      endcase
    end
    assign en[i] = en_l;

    gpt_counter #(.W(W)) u_cnt (
      .clk, .rst_n, .wr(wr[i]), .wval(reg_wdata), .ld(ld[i]), .lval(lval[i]),
      .en(en[i]), .down(dn[i]), .cnt(cnt[i]), .wrap(wrap[i])
    );

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_q[i] && !(reg_we && reg_addr == A_FLAGS && reg_wdata[i])) |=> fl_q[i]); // R10
  end

  always_comb begin
    logic seen;
    seen    = 1'b0;
    rld_mux = '0;
    for (int i = 0; i < NTMR; i++) begin
      rld_win[i] = rld[i] & ~seen;
      seen       = seen | rld[i];
      if (rld_win[i]) rld_mux = cnt[i];
    end
  end

  assign fl_set = wrap | cap | rld_win;
  assign fl_clr = (reg_we && reg_addr == A_FLAGS) ? reg_wdata[NTMR-1:0] : '0;
  assign fl_d   = (fl_q & ~fl_clr) | fl_set;
  assign tl_d   = tl_q ^ wrap[0];

  always_comb begin
    for (int i = 0; i < NTMR; i++) begin
      ctrl_d[i] = (reg_we && reg_addr == 3'(i + NTMR)) ?
                  tctrl_t'(reg_wdata[CW-1:0]) : ctrl_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      fl_q   <= '0;
      tl_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      fl_q   <= fl_d;
      tl_q   <= tl_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NTMR; i++) begin
      if (reg_addr == 3'(i))        reg_rdata = cnt[i];
      if (reg_addr == 3'(i + NTMR)) reg_rdata = W'(ctrl_q[i]);
    end
    if (reg_addr == A_FLAGS) reg_rdata = W'({tl_q, fl_q});
  end

  assign core_tl = tl_q;
  assign irq     = fl_q;

  AST_TL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap[0] |=> core_tl != $past(core_tl)); // R6
  AST_TL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap[0] |=> $stable(core_tl)); // R6
  AST_ONE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rld_win)); // R9
endmodule

// File: tb/tb_gpt_cluster.sv
module tb_gpt_cluster;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [2:0]  tin, tdir;
  logic        core_tl;
  logic [2:0]  irq;
  bit          done = 0;

  always #5 clk = ~clk;

  gpt_cluster dut (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .tin, .tdir, .core_tl, .irq
  );

  int n_chk = 0, n_fail = 0;

  // behavioural reference state
  int m_cnt[3], m_ctl[3], m_fl, m_tl, m_psc;
  int p1[3], p2[3], p3[3], q1[3], q2[3];

  function automatic int exp_rd(int a);
    if (a < 3) return m_cnt[a];
    if (a < 6) return m_ctl[a-3];
    if (a == 6) return (m_tl << 3) | m_fl;
    return 0;
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_fl = 0; m_tl = 0; m_psc = 0;
      for (int i = 0; i < 3; i++) begin
        m_cnt[i] = 0; m_ctl[i] = 0; p1[i] = 0; p2[i] = 0; p3[i] = 0; q1[i] = 0; q2[i] = 0;
      end
    end else begin
      int en[3], dn[3], pev[3], wrp[3], tle[3], cap[3], rl[3], win[3], nc[3];
      int c, md, run, per, sr, sf, src, spec, set, clr;
      for (int i = 0; i < 3; i++) begin
        c = m_ctl[i]; md = c & 3; run = (c >> 2) & 1;
        sr = (c >> 8) & 1; sf = (c >> 9) & 1;
        dn[i] = ((c >> 3) & 1) ^ (((c >> 4) & 1) & q2[i]);
        per = 1 << (((c >> 5) & 7) + 1);
        pev[i] = ((sr != 0) && p2[i] == 1 && p3[i] == 0) || ((sf != 0) && p2[i] == 0 && p3[i] == 1);
        tle[i] = 0; cap[i] = 0; rl[i] = 0;
        if (i > 0) begin
          tle[i] = wrp[0] && ((sr != 0 && m_tl == 0) || (sf != 0 && m_tl == 1));
          src = ((c >> 11) & 1) ? tle[i] : pev[i];
          spec = run && md == 3;
          cap[i] = spec && ((c >> 10) & 1) == 0 && pev[i];
          rl[i] = spec && ((c >> 10) & 1) == 1 && (((c >> 12) & 1) ? tle[i] : pev[i]);
        end else src = pev[0];
        case (md)
          0: en[i] = run && ((m_psc % per) == per - 1);
          1: en[i] = run && ((m_psc % per) == per - 1) && p2[i] == 1;
          2: en[i] = run && src;
          default: en[i] = 0;
        endcase
        wrp[i] = en[i] && (dn[i] ? m_cnt[i] == 0 : m_cnt[i] == 65535);
      end
      win[0] = 0; win[1] = rl[1]; win[2] = rl[2] && !rl[1];
      for (int i = 0; i < 3; i++) begin
        nc[i] = m_cnt[i];
        if (reg_we && reg_addr == i) nc[i] = reg_wdata;
        else if (i == 0 && (win[1] || win[2])) nc[i] = win[1] ? m_cnt[1] : m_cnt[2];
        else if (i > 0 && cap[i]) nc[i] = m_cnt[0];
        else if (en[i]) nc[i] = (dn[i] ? m_cnt[i] - 1 : m_cnt[i] + 1) & 16'hFFFF;
      end
      set = 0;
      for (int i = 0; i < 3; i++) if (wrp[i] || cap[i] || win[i]) set |= 1 << i;
      clr = (reg_we && reg_addr == 6) ? (reg_wdata & 7) : 0;
      m_fl = (m_fl & ~clr) | set;
      m_tl = m_tl ^ wrp[0];
      for (int i = 0; i < 3; i++) begin
        m_cnt[i] = nc[i];
        if (reg_we && reg_addr == i + 3) m_ctl[i] = reg_wdata & 16'h1FFF;
        p3[i] = p2[i]; p2[i] = p1[i]; p1[i] = tin[i];
        q2[i] = q1[i]; q1[i] = tdir[i];
      end
      m_psc = (m_psc + 1) & 255;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R11 read port", reg_rdata, exp_rd(reg_addr));
      chk("R6 toggle latch", core_tl, m_tl);
      chk("R10 irq flags", irq, m_fl);
    end
  end

  task automatic wr_reg(int a, int d);
    @(posedge clk); #1;
    reg_we = 1; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pchk(string tag, int a);
    @(posedge clk); #1;
    reg_addr = 3'(a);
    @(negedge clk);
    chk(tag, reg_rdata, exp_rd(a));
  endtask

  task automatic flip(int i, int hold);
    @(posedge clk); #1;
    tin[i] = ~tin[i];
    idle(hold);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0; tin = 0; tdir = 0;
    idle(4);
    @(posedge clk); #1 rst_n = 1;
    // R1: reset values, checked against fixed zeros
    for (int a = 0; a < 7; a++) begin
      @(posedge clk); #1 reg_addr = 3'(a);
      @(negedge clk); chk("R1 reset value", reg_rdata, 0);
    end
    // R2: core timer mode, prescale select 1
    wr_reg(3, 16'h0024);
    idle(40);
    pchk("R2 prescaled count", 0);
    // R5/R6: count down through zero
    wr_reg(0, 3);
    wr_reg(3, 16'h002C);
    idle(30);
    pchk("R6 underflow value", 0);
    pchk("R6 flag and latch", 6);
    // R5: direction pin inverts
    wr_reg(3, 16'h0034);
    @(posedge clk); #1 tdir[0] = 1;
    idle(30);
    pchk("R5 direction pin", 0);
    @(posedge clk); #1 tdir[0] = 0;
    // R10: clear core flag
    wr_reg(6, 1);
    pchk("R10 flag clear", 6);
    // R3: gated aux0
    wr_reg(4, 16'h0005);
    flip(1, 12); flip(1, 10); flip(1, 7); flip(1, 9);
    pchk("R3 gated count", 1);
    // R4: aux1 counts both edges
    wr_reg(5, 16'h0306);
    for (int k = 0; k < 6; k++) flip(2, 3);
    idle(4);
    pchk("R4 edge count", 2);
    wr_reg(5, 16'h0106);
    for (int k = 0; k < 6; k++) flip(2, 2);
    idle(4);
    pchk("R4 rising only", 2);
    // R7: cascade aux1 on latch rising
    wr_reg(3, 16'h0004);
    wr_reg(5, 16'h0906);
    for (int k = 0; k < 4; k++) begin
      wr_reg(0, 16'hFFFA);
      idle(16);
    end
    pchk("R7 cascade count", 2);
    // R8: capture into aux0
    wr_reg(4, 16'h0107);
    flip(1, 5); flip(1, 5);
    pchk("R8 captured value", 1);
    // R9: reload from aux1 on pin edge
    wr_reg(2, 16'h1234);
    wr_reg(5, 16'h0507);
    flip(2, 5);
    pchk("R9 pin reload", 0);
    flip(2, 5);
    // R9: reload on both latch transitions, captures interleaved
    wr_reg(2, 16'hFFF0);
    wr_reg(5, 16'h1707);
    wr_reg(4, 16'h0307);
    wr_reg(0, 16'hFFF8);
    for (int k = 0; k < 40; k++) flip(1, 4 + (k % 3));
    pchk("R9 latch reload", 0);
    pchk("R8 capture at reload", 1);
    // R9: both auxiliaries reload on the same pin edge
    wr_reg(1, 16'h0AAA);
    wr_reg(4, 16'h0507);
    wr_reg(5, 16'h0507);
    @(posedge clk); #1 tin[1] = ~tin[1]; tin[2] = ~tin[2];
    idle(5);
    pchk("R9 first auxiliary wins", 0);
    // R10: write clear while set
    wr_reg(6, 7);
    pchk("R10 clear all", 6);
    pchk("R11 unused address", 7);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule